// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Clock Divider

This block divides a fast input clock by a programmable ratio built from two counters around an 8/9 dual-modulus prescaler. A 14-bit ratio word holds a 3-bit swallow count A and an 11-bit main count M. Each output period is made of M prescaler periods. The first A of them are nine input cycles long and the rest are eight, so the period is 8·M + A input cycles. Because the word places A below M, the period in input cycles equals the numeric value of the ratio word whenever M ≥ A.

There is no load strobe. The ratio word is read on the input-clock edge that starts a new output period, and that value governs the whole period. A change made partway through a period takes effect at the next boundary, so no period is cut short. The output is a single pulse per period. It rises at the start of the period and stays high for one divide-by-8 prescaler period. The block suits a frequency synthesiser feedback path or any fast integer divider that must step through every ratio from 56 upward.

Top module: `pulse_swallow_div`

## Requirements
- R1: The ratio word is split as A = bits [2:0] and M = bits [13:3]. With M ≥ A and M ≥ 1, the output pulse repeats every 8·M + A input-clock cycles, which equals the numeric value of the word.
- R2: Within each output period, the first A prescaler periods last 9 input cycles and the remaining M − A prescaler periods last 8. The period therefore grows by exactly one cycle for each unit of A.
- R3: The output pulse goes high on the first input cycle of each output period and stays high for exactly 8 input cycles.
- R4: Every integer ratio from 56 up to 16383 is produced exactly. This includes the steps across a change of M at 63→64 and the smallest contiguous value, 56.
- R5: The ratio word is sampled only on the edge that begins an output period. A change applied partway through a period leaves that period's length unchanged, and the following period uses the new word.
- R6: When M < A, every prescaler period in the output period lasts 9 cycles, giving 9·M cycles. A value of M = 0 is treated as M = 1.
- R7: While the reset input is low, the output pulse is low. After reset is released, pulses start without any load action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_i | input | 14 | Ratio word: swallow count in [2:0], main count in [13:3] |
| pulse_o | output | 1 | Divided output, one 8-cycle pulse per output period |

## Verification
The ratios 56 and 57 separate a correct swallow count from one that ignores A. The ratios 63 and 64 show the carry from A into M and reveal a swallow counter that keeps running into the 8-cycle periods. Ratios 1000 and 16383 exercise long main-count runs and the all-ones word. A word with M below A checks that the main count still ends the period. A ratio change made in the middle of a period separates sampling at the boundary from transparent use of the live word, and each pulse width is measured to catch a pulse stretched to 9 cycles by a swallowed first period.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned SWALLOW_W = 3;
  localparam int unsigned MAIN_W    = 11;
  localparam int unsigned WORD_W    = SWALLOW_W + MAIN_W;
  localparam int unsigned PRE_BASE  = 8;
  localparam int unsigned PHASE_W   = $clog2(PRE_BASE + 1);

  typedef struct packed {
    logic [MAIN_W-1:0]    main_cnt;
    logic [SWALLOW_W-1:0] swallow_cnt;
  } ratio_word_t;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned PRE_N = 8,
  localparam int unsigned PH_W = $clog2(PRE_N + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            swallow_i,
  output logic            tc_o,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] LAST_LO = PH_W'(PRE_N - 1);
  localparam logic [PH_W-1:0] LAST_HI = PH_W'(PRE_N);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_en;

  assign tc_o = (ph_q == (swallow_i ? LAST_HI : LAST_LO));

  always_comb begin
    ph_en = 1'b1;
    if (load_i || tc_o) ph_d = '0;
    else                ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  AST_MOD8_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swallow_i |-> ph_q <= LAST_LO); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o || load_i) |=> ph_q == '0); // R2
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
  parameter int unsigned A_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           tc_i,
  input  logic [A_W-1:0] a_i,
  output logic           swallow_o
);
  logic [A_W-1:0] a_q, a_d;
  logic           a_en;

  assign swallow_o = (a_q != '0);

  always_comb begin
    a_en = load_i || (tc_i && swallow_o);
    if (load_i) a_d = a_i;
    else        a_d = a_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   a_q <= '0;
    else if (a_en) a_q <= a_d;
  end

  AST_A_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> a_q == $past(a_i)); // R1
  AST_A_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && !load_i && a_q != '0) |=> a_q == $past(a_q) - 1'b1); // R2
endmodule

// File: rtl/psd_main_ctr.sv
module psd_main_ctr #(
  parameter int unsigned M_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tc_i,
  input  logic [M_W-1:0] m_i,
  output logic           load_o
);
  logic [M_W-1:0] m_q, m_d, m_reload;
  logic           start_q;
  logic           m_en;

  assign m_reload = (m_i == '0) ? '0 : m_i - 1'b1;
  assign load_o   = start_q || (tc_i && m_q == '0);

  always_comb begin
    m_en = load_o || tc_i;
    if (load_o) m_d = m_reload;
    else        m_d = m_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q     <= '0;
      start_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
      if (m_en) m_q <= m_d;
    end
  end

  AST_M_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_i && !load_o) |=> $stable(m_q)); // R5
  AST_M_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && !load_o) |=> m_q == $past(m_q) - 1'b1); // R1
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] ratio_i,
  output logic              pulse_o
);
  localparam logic [PHASE_W-1:0] PULSE_LAST = PHASE_W'(PRE_BASE - 1);

  ratio_word_t        word;
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic               load, tc, swallow;
  logic [PHASE_W-1:0] phase;
  logic               pulse_q, pulse_d, pulse_en;

  assign word = ratio_word_t'(ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  psd_prescaler #(.PRE_N(PRE_BASE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_n_int), .load_i(load), .swallow_i(swallow),
    .tc_o(tc), .phase_o(phase)
  );

  psd_swallow_ctr #(.A_W(SWALLOW_W)) u_swallow (
    .clk_i(clk_i), .rst_ni(rst_n_int), .load_i(load), .tc_i(tc),
    .a_i(word.swallow_cnt), .swallow_o(swallow)
  );

  psd_main_ctr #(.M_W(MAIN_W)) u_main (
    .clk_i(clk_i), .rst_ni(rst_n_int), .tc_i(tc), .m_i(word.main_cnt),
    .load_o(load)
  );

  always_comb begin
    pulse_en = 1'b1;
    pulse_d  = load || (pulse_q && phase != PULSE_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int)    pulse_q <= 1'b0;
    else if (pulse_en) pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    load |=> (pulse_q && phase == '0)); // R3
  AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (pulse_q && phase == PULSE_LAST && !load) |=> !pulse_q); // R3
endmodule

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] ratio;
  logic        pulse;
  logic        prev;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam int NV = 7;
  localparam logic [13:0] VEC_WORD [NV] = '{14'd56, 14'd57, 14'd63, 14'd64,
                                            14'd1000, 14'd16383, 14'd21};
  localparam int VEC_PER [NV] = '{56, 57, 63, 64, 1000, 16383, 18};
  localparam string VEC_REQ [NV] = '{"R4", "R2", "R1", "R4", "R1", "R4", "R6"};

  always #10 clk = ~clk;

  pulse_swallow_div u_pulse_swallow_div (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .pulse_o(pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    forever begin
      @(negedge clk);
      if (pulse && !prev) begin prev = pulse; break; end
      prev = pulse;
    end
  endtask

  task automatic measure(output int per, output int wid, input int chg_at,
                         input logic [13:0] chg_word);
    per = 0; wid = 1;
    forever begin
      @(negedge clk);
      per++;
      if (per == chg_at) ratio = chg_word;
      if (pulse && !prev) begin prev = pulse; break; end
      if (pulse) wid++;
      prev = pulse;
    end
  endtask

  initial begin
    int p, w;
    rst_n = 1'b0;
    ratio = 14'd56;
    prev  = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 low in reset", int'(pulse), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      ratio = VEC_WORD[i];
      wait_rise();
      measure(p, w, 0, 14'd0);
      check({VEC_REQ[i], " period"}, p, VEC_PER[i]);
      check("R3 width", w, 8);
    end
    // R5: change word partway through a 64-cycle period
    ratio = 14'd64;
    wait_rise();
    measure(p, w, 0, 14'd0);
    measure(p, w, 10, 14'd100);
    check("R5 current period kept", p, 64);
    measure(p, w, 0, 14'd0);
    check("R5 next period new", p, 100);
    // R7: reset mid-run forces pulse low
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 low after reset", int'(pulse), 0);
    rst_n = 1'b1;
    prev = 1'b0;
    ratio = 14'd57;
    wait_rise();
    measure(p, w, 0, 14'd0);
    check("R7 restart period", p, 57);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule